// File: doc/BRIEF.md
# Power-Fail Chip-Enable Write-Protect Gate

This controller sits on the chip-enable path of an external static RAM. It watches an 8-bit digitized sample of the main supply. When that sample falls below a trip level, it stops chip-enable requests from reaching the memory, so a collapsing supply cannot corrupt the stored contents. A select input picks one of two trip levels. One suits a supply held within 5% of nominal (about 4.62 V). The other suits a 10% supply (about 4.37 V).

The gate behaves differently depending on whether an access is running when the failure is seen:

- **Access in progress:** it is allowed to finish, because cutting it short could leave a half-written word. Only a bounded number of clock cycles is granted. After that the enable is forced inactive whatever the requester does.
- **No access in progress:** the output is blocked at once.

After a failure the memory stays write-protected until the supply has recovered. The sample must climb past the trip level plus a small hysteresis margin. It must then stay there for a set run of consecutive cycles. While the gate is not in normal operation, a status output names which of two backup sources should feed the memory.

In normal operation the enable passes straight through with no register in the path, to keep the propagation delay short.

Top module: `pfwp_gate`

## Requirements
- R1: After the supply has been judged out of tolerance with no access in progress, `ce_mem_n` is 1 for every value of `ce_req_n` until the gate returns to pass-through.
- R2: The supply is out of tolerance when `supply_code` < `TRIP_5PCT` (default 236) with `thresh_sel`=0. It is out of tolerance when `supply_code` < `TRIP_10PCT` (default 223) with `thresh_sel`=1. A code equal to the selected trip level is in tolerance.
- R3: In pass-through operation `ce_mem_n` equals `ce_req_n` in the same cycle, with no clock edge in between.
- R4: If the first clock edge that sees the supply out of tolerance also sees `ce_req_n`=0, then:
  - `ce_mem_n` keeps following `ce_req_n` until `ce_req_n` returns to 1;
  - from the next edge onward `ce_mem_n` stays 1, so a later falling `ce_req_n` is not passed.
- R5: If `ce_req_n` is still 0 after `WPT_CYCLES` clock edges following the detecting edge, `ce_mem_n` becomes 1 after the next edge and stays 1.
- R6: The gate returns to pass-through only after the supply code has been at or above (selected trip + 2) for `VALID_CYCLES` consecutive edges. Pass-through begins after edge `VALID_CYCLES`+1 of that run. A single sample below that level restarts the count.
- R7: A supply code of exactly trip or trip+1 does not end write protection, however long it is held. In pass-through it does not cause a trip either.
- R8: `backup_sel` is 0 in pass-through operation. Outside it, `backup_sel` is 0 (source 1) when `bk1_good`=1 and 1 (source 2) when `bk1_good`=0.
- R9: `write_protected` is 0 in pass-through and while an interrupted access drains. It is 1 once the output is being blocked and during recovery.
- R10: After reset the gate is write-protected: `ce_mem_n`=1 and `write_protected`=1 even with `ce_req_n`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_code | input | 8 | Digitized main-supply sample |
| thresh_sel | input | 1 | 0 selects the 5% trip level, 1 selects the 10% trip level |
| ce_req_n | input | 1 | Active-low chip-enable request from the memory master |
| bk1_good | input | 1 | Backup source 1 is usable |
| ce_mem_n | output | 1 | Active-low conditioned chip-enable to the RAM |
| backup_sel | output | 1 | 0 picks backup source 1, 1 picks source 2 |
| write_protected | output | 1 | Memory is currently write-protected |

## Verification
The bench builds the gate with `VALID_CYCLES`=4 and `WPT_CYCLES`=6, and keeps the default trip codes of 236 and 223. The short windows make the exact cycles reachable in a few dozen clocks:

- the edge on which a draining access is cut off;
- the edge on which recovery ends;
- a recovery run that is broken and then restarted.

With the default trip codes, the table of supply samples lands exactly on each trip boundary and inside the hysteresis band.

// File: rtl/pfwp_pkg.sv
package pfwp_pkg;

    localparam int SUPPLY_W = 8;

    typedef logic [SUPPLY_W-1:0] supply_t;

    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_PROTECT = 2'd2,
        ST_RECOVER = 2'd3
    } gate_state_e;

    typedef struct packed {
        logic out_of_tol;
        logic level_good;
    } supply_stat_t;

    function automatic supply_t pick_trip(input logic sel, input supply_t lvl5,
                                          input supply_t lvl10);
        return sel ? lvl10 : lvl5;
    endfunction

    function automatic logic at_or_above(input supply_t code, input supply_t base,
                                         input supply_t margin);
        logic [SUPPLY_W:0] need;
        need = {1'b0, base} + {1'b0, margin};
        return {1'b0, code} >= need;
    endfunction

endpackage

// File: rtl/pfwp_supply_mon.sv
module pfwp_supply_mon
    import pfwp_pkg::*;
#(
    parameter supply_t TRIP_5PCT  = 8'd236,
    parameter supply_t TRIP_10PCT = 8'd223,
    parameter supply_t HYST       = 8'd2
) (
    input  logic         clk,
    input  logic         rst,
    input  supply_t      supply_code,
    input  logic         thresh_sel,
    output supply_stat_t stat
);

    supply_t trip_lvl;

    always_comb begin
        trip_lvl        = pick_trip(thresh_sel, TRIP_5PCT, TRIP_10PCT);
        stat.out_of_tol = supply_code < trip_lvl;
        stat.level_good = at_or_above(supply_code, trip_lvl, HYST);
    end

    // A sample cannot be both failing and good enough to recover.
    assert_level_order_R7: assert property (@(posedge clk) disable iff (rst)
        stat.out_of_tol |-> !stat.level_good);

endmodule

// File: rtl/pfwp_valid_qual.sv
module pfwp_valid_qual #(
    parameter int VALID_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic level_good,
    output logic power_valid
);

    generate
        if (VALID_CYCLES <= 0) begin : g_direct
            assign power_valid = level_good;
        end else begin : g_count
            localparam int CNT_W = $clog2(VALID_CYCLES + 1);
            localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(VALID_CYCLES);
            logic [CNT_W-1:0] run_cnt;

            always_ff @(posedge clk) begin
                if (rst || !level_good) begin
                    run_cnt <= '0;
                end else if (run_cnt != CNT_MAX) begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end

            assign power_valid = (run_cnt == CNT_MAX);
        end
    endgenerate

    // A sample below the recovery level always restarts qualification.
    assert_valid_clear_R6: assert property (@(posedge clk) disable iff (rst)
        !level_good |=> !power_valid);

endmodule

// File: rtl/pfwp_gate_fsm.sv
module pfwp_gate_fsm
    import pfwp_pkg::*;
#(
    parameter int WPT_CYCLES = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        out_of_tol,
    input  logic        level_good,
    input  logic        power_valid,
    input  logic        ce_req_n,
    input  logic        bk1_good,
    output logic        ce_mem_n,
    output logic        backup_sel,
    output logic        write_protected,
    output gate_state_e state
);

    localparam int CNT_W = $clog2(WPT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WPT_CYCLES - 1);

    gate_state_e      nxt;
    logic [CNT_W-1:0] drain_cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_NORMAL:  if (out_of_tol) nxt = ce_req_n ? ST_PROTECT : ST_DRAIN;
            ST_DRAIN:   if (ce_req_n || drain_cnt == CNT_LAST) nxt = ST_PROTECT;
            ST_PROTECT: if (level_good) nxt = ST_RECOVER;
            ST_RECOVER: begin
                if (!level_good)      nxt = ST_PROTECT;
                else if (power_valid) nxt = ST_NORMAL;
            end
            default:    nxt = ST_PROTECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_PROTECT;
            drain_cnt <= '0;
        end else begin
            state     <= nxt;
            drain_cnt <= (state == ST_DRAIN) ? drain_cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        write_protected = (state == ST_PROTECT) || (state == ST_RECOVER);
        ce_mem_n        = write_protected ? 1'b1 : ce_req_n;
        backup_sel      = (state != ST_NORMAL) && !bk1_good;
    end

    assert_drain_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN) |-> (drain_cnt < CNT_W'(WPT_CYCLES)));

    assert_drain_end_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN && ce_req_n) |=> (state == ST_PROTECT));

    assert_protect_exit_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROTECT) |=> (state == ST_PROTECT || state == ST_RECOVER));

    assert_enter_normal_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_NORMAL && $past(state) != ST_NORMAL) |-> $past(power_valid));

endmodule

// File: rtl/pfwp_gate.sv
module pfwp_gate
    import pfwp_pkg::*;
#(
    parameter supply_t TRIP_5PCT    = 8'd236,
    parameter supply_t TRIP_10PCT   = 8'd223,
    parameter supply_t HYST         = 8'd2,
    parameter int      VALID_CYCLES = 16,
    parameter int      WPT_CYCLES   = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] supply_code,
    input  logic       thresh_sel,
    input  logic       ce_req_n,
    input  logic       bk1_good,
    output logic       ce_mem_n,
    output logic       backup_sel,
    output logic       write_protected
);

    supply_stat_t stat;
    logic         power_valid;
    gate_state_e  state;

    pfwp_supply_mon #(
        .TRIP_5PCT (TRIP_5PCT),
        .TRIP_10PCT(TRIP_10PCT),
        .HYST      (HYST)
    ) u_mon (
        .clk        (clk),
        .rst        (rst),
        .supply_code(supply_code),
        .thresh_sel (thresh_sel),
        .stat       (stat)
    );

    pfwp_valid_qual #(
        .VALID_CYCLES(VALID_CYCLES)
    ) u_qual (
        .clk        (clk),
        .rst        (rst),
        .level_good (stat.level_good),
        .power_valid(power_valid)
    );

    pfwp_gate_fsm #(
        .WPT_CYCLES(WPT_CYCLES)
    ) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .out_of_tol     (stat.out_of_tol),
        .level_good     (stat.level_good),
        .power_valid    (power_valid),
        .ce_req_n       (ce_req_n),
        .bk1_good       (bk1_good),
        .ce_mem_n       (ce_mem_n),
        .backup_sel     (backup_sel),
        .write_protected(write_protected),
        .state          (state)
    );

    // Write protection at the ports always means a blocked enable.
    assert_wp_blocks_R1: assert property (@(posedge clk) disable iff (rst)
        write_protected |-> ce_mem_n);

    // A failing sample seen in pass-through with no access blocks from the next cycle.
    assert_idle_trip_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_NORMAL && stat.out_of_tol && ce_req_n) |=> write_protected);

endmodule

// File: tb/tb_pfwp_gate.sv
`timescale 1ns/1ps
module tb_pfwp_gate;

    localparam int VALID = 4;
    localparam int WPT   = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] supply_code = 8'd240;
    logic       thresh_sel = 1'b0;
    logic       ce_req_n = 1'b1;
    logic       bk1_good = 1'b1;
    logic       ce_mem_n, backup_sel, write_protected;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    pfwp_gate #(.VALID_CYCLES(VALID), .WPT_CYCLES(WPT)) dut (
        .clk(clk), .rst(rst), .supply_code(supply_code), .thresh_sel(thresh_sel),
        .ce_req_n(ce_req_n), .bk1_good(bk1_good), .ce_mem_n(ce_mem_n),
        .backup_sel(backup_sel), .write_protected(write_protected)
    );

    // {supply code, threshold select, expected trip}
    localparam logic [9:0] VEC [10] = '{
        {8'd236, 1'b0, 1'b0}, {8'd235, 1'b0, 1'b1}, {8'd223, 1'b1, 1'b0},
        {8'd222, 1'b1, 1'b1}, {8'd230, 1'b1, 1'b0}, {8'd230, 1'b0, 1'b1},
        {8'd255, 1'b0, 1'b0}, {8'd0,   1'b1, 1'b1}, {8'd237, 1'b0, 1'b0},
        {8'd224, 1'b1, 1'b0}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic recover();
        supply_code = 8'd240;
        step(VALID + 1);
        #1 check("R6 recovery complete", write_protected, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        ce_req_n = 1'b0;
        #1;
        check("R10 reset ce_mem_n", ce_mem_n, 1'b1);
        check("R10 reset write_protected", write_protected, 1'b1);
        ce_req_n = 1'b1;

        // R6: first recovery from reset, exact edge.
        step(VALID);
        #1 check("R6 still protected at VALID edges", write_protected, 1'b1);
        step(1);
        #1 check("R6 pass-through after VALID+1 edges", write_protected, 1'b0);

        // R3 / R9 / R8 in pass-through.
        ce_req_n = 1'b0;
        #1 check("R3 pass low", ce_mem_n, 1'b0);
        check("R9 wp low in normal", write_protected, 1'b0);
        bk1_good = 1'b0;
        #1 check("R8 backup_sel zero in normal", backup_sel, 1'b0);
        ce_req_n = 1'b1;
        #1 check("R3 pass high", ce_mem_n, 1'b1);
        bk1_good = 1'b1;

        // R2 / R7 threshold table.
        for (int i = 0; i < 10; i++) begin
            step(1);
            supply_code = VEC[i][9:2];
            thresh_sel  = VEC[i][1];
            step(1);
            #1 check($sformatf("R2 trip vector %0d", i), write_protected, VEC[i][0]);
            supply_code = 8'd240;
            if (VEC[i][0]) begin
                recover();
            end else begin
                step(1);
            end
        end
        thresh_sel = 1'b0;

        // R1 / R8: idle trip blocks and selects backup.
        supply_code = 8'd200;
        step(1);
        ce_req_n = 1'b0;
        #1 check("R1 blocked with request low", ce_mem_n, 1'b1);
        check("R8 source 1 when good", backup_sel, 1'b0);
        bk1_good = 1'b0;
        #1 check("R8 source 2 when bk1 bad", backup_sel, 1'b1);
        bk1_good = 1'b1;
        ce_req_n = 1'b1;

        // R7: hysteresis band holds protection.
        supply_code = 8'd237;
        step(VALID + 3);
        #1 check("R7 trip+1 keeps protection", write_protected, 1'b1);
        supply_code = 8'd236;
        step(VALID + 3);
        #1 check("R7 trip keeps protection", write_protected, 1'b1);

        // R6: broken recovery run restarts.
        supply_code = 8'd240;
        step(2);
        supply_code = 8'd237;
        step(1);
        supply_code = 8'd240;
        step(VALID);
        #1 check("R6 restarted count not yet done", write_protected, 1'b1);
        step(1);
        #1 check("R6 restarted count done", write_protected, 1'b0);

        // R4: access in progress drains, then new request blocked.
        step(1);
        ce_req_n = 1'b0;
        supply_code = 8'd200;
        #1 check("R4 access passes at detection", ce_mem_n, 1'b0);
        step(1);
        #1 check("R4 drain still passes", ce_mem_n, 1'b0);
        check("R9 wp low while draining", write_protected, 1'b0);
        step(2);
        ce_req_n = 1'b1;
        #1 check("R4 access end seen", ce_mem_n, 1'b1);
        step(1);
        ce_req_n = 1'b0;
        #1 check("R4 new request blocked", ce_mem_n, 1'b1);
        check("R9 wp high after drain", write_protected, 1'b1);
        ce_req_n = 1'b1;
        recover();

        // R5: drain timeout.
        step(1);
        ce_req_n = 1'b0;
        supply_code = 8'd200;
        step(WPT);
        #1 check("R5 still passing at WPT edges", ce_mem_n, 1'b0);
        step(1);
        #1 check("R5 forced inactive after timeout", ce_mem_n, 1'b1);
        check("R5 wp after timeout", write_protected, 1'b1);
        step(3);
        #1 check("R5 stays inactive", ce_mem_n, 1'b1);
        ce_req_n = 1'b1;
        recover();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule